// File: doc/BRIEF.md
# Framed SPI Command Receiver with Parity and Length Checking

This block is the serial front end of a multi-channel output controller. A host selects it by pulling chip select low and then clocks whole 16-bit words through it. Command bits arrive on the data-in line, most significant bit first, and a status word leaves on the data-out line at the same time. The serial pins are sampled in the block's own system clock domain. Both edges of the serial clock are recovered from the sampled value.

When chip select rises, the frame is judged. It passes only if it held a nonzero whole number of 16-clock words and the last 16 bits shifted in have an odd number of ones. A passing frame delivers that 16-bit word on a single-cycle strobe. A failing frame delivers nothing and raises a parity or a frame error on outputs of its own, apart from any fault reporting. Longer frames let several devices share one chain. Once the local status word has gone out, data-out repeats data-in delayed by 16 bits.

Top module: `spi_cmd_slave`

## Requirements
- R1: While `rst` is high and after it falls, `cmd_word` is 0 and `cmd_valid`, `parity_err`, `frame_err` and `spi_so_oe` are low until a frame completes.
- R2: `spi_so_oe` is high exactly while `spi_cs_n` is low. Data-out is released whenever chip select is high.
- R3: Data-in is captured on rising serial clock edges, most significant bit first. The word judged at frame end is the last 16 captured bits, with bit 15 captured first.
- R4: `status_word` is sampled when chip select falls. Its bit 15 is on data-out before the first rising edge, and each falling edge moves to the next lower bit.
- R5: After all 16 status bits, each falling edge puts on data-out the data-in bit captured 16 rising edges earlier, so chained frames pass through.
- R6: A frame whose count of rising serial clock edges is zero or not a multiple of 16 sets `frame_err` and commits nothing.
- R7: Odd parity: if the judged word has an even number of ones, `parity_err` is set and nothing is committed. This is evaluated whatever the frame length.
- R8: When a frame has no error, `cmd_word` takes the judged word and `cmd_valid` pulses for exactly one clock. At all other times `cmd_word` holds its value.
- R9: Both error flags are rewritten at the end of every frame, so a clean frame clears them.
- R10: Chip select falling clears the edge count and the capture register. A frame with fewer than 16 edges is judged on its own bits alone, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from host, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for the data-out pad driver |
| status_word | input | 16 | Word to shift out, sampled at chip select fall |
| cmd_word | output | 16 | Last committed command word |
| cmd_valid | output | 1 | One-cycle strobe when `cmd_word` is updated |
| parity_err | output | 1 | Last frame's judged word had even parity |
| frame_err | output | 1 | Last frame's edge count was invalid |

## Verification
A wrong bit counter shows when chip select rises. A legal length is then reported as `frame_err`, or a bad one is accepted, within about four system clocks. A stale or misordered capture register shows as a wrong `cmd_word` or a wrong `parity_err` on that same frame. Frames of zero, short and chained lengths expose a capture register that was not cleared. A fault in the transmit shift path appears on data-out at the very next low phase of the serial clock. Comparing every data-out bit of every frame localises such a fault to a single bit time.

// File: rtl/spi_chk_pkg.sv
package spi_chk_pkg;

    localparam int WORD_W      = 16;
    localparam int SYNC_STAGES = 2;

    // Events recovered from the synchronised serial pins
    typedef struct packed {
        logic sclk_rise;
        logic sclk_fall;
        logic cs_fall;
        logic cs_rise;
    } spi_evt_t;

    // Verdict of one completed frame
    typedef struct packed {
        logic done;
        logic len_bad;
        logic par_bad;
    } frame_verdict_t;

    typedef enum logic {
        FR_IDLE   = 1'b0,
        FR_ACTIVE = 1'b1
    } frame_state_e;

    function automatic logic ones_odd(input logic [WORD_W-1:0] w);
        return ^w;
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int N_SIG  = 3,
    parameter int STAGES = spi_chk_pkg::SYNC_STAGES,
    parameter logic [N_SIG-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SIG-1:0] d_in,
    output logic [N_SIG-1:0] q_out
);

    for (genvar g = 0; g < N_SIG; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{RST_VAL[g]}};
            else     chain <= {chain[STAGES-2:0], d_in[g]};
        end
        assign q_out[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det
    import spi_chk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk_s,
    input  logic     csn_s,
    output spi_evt_t evt
);

    logic sclk_q;
    logic csn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            csn_q  <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            csn_q  <= csn_s;
        end
    end

    always_comb begin
        evt.sclk_rise = sclk_s & ~sclk_q & ~csn_s;
        evt.sclk_fall = ~sclk_s & sclk_q & ~csn_s;
        evt.cs_fall   = ~csn_s & csn_q;
        evt.cs_rise   = csn_s & ~csn_q;
    end

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import spi_chk_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic           clk,
    input  logic           rst,
    input  spi_evt_t       evt,
    input  logic           si_s,
    output logic [W-1:0]   rx_word,
    output logic           rx_lsb,
    output frame_verdict_t verdict
);

    localparam int IDX_W = $clog2(W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(W - 1);

    frame_state_e     state;
    logic [IDX_W-1:0] bit_idx;
    logic             any_clk;
    logic [W-1:0]     rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= FR_IDLE;
            bit_idx <= '0;
            any_clk <= 1'b0;
            rx_q    <= '0;
        end else if (evt.cs_fall) begin
            state   <= FR_ACTIVE;
            bit_idx <= '0;
            any_clk <= 1'b0;
            rx_q    <= '0;
        end else if (evt.cs_rise) begin
            state   <= FR_IDLE;
        end else if (evt.sclk_rise && state == FR_ACTIVE) begin
            rx_q    <= {rx_q[W-2:0], si_s};
            any_clk <= 1'b1;
            bit_idx <= (bit_idx == IDX_LAST) ? '0 : bit_idx + 1'b1;
        end
    end

    always_comb begin
        verdict.done    = evt.cs_rise & (state == FR_ACTIVE);
        verdict.len_bad = ~any_clk | (bit_idx != '0);
        verdict.par_bad = ~ones_odd(rx_q);
    end

    assign rx_word = rx_q;
    assign rx_lsb  = rx_q[0];

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift
    import spi_chk_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  spi_evt_t     evt,
    input  logic [W-1:0] load_word,
    input  logic         chain_bit,
    output logic         so_bit
);

    logic [W-1:0] tx_q;

    always_ff @(posedge clk) begin
        if (rst)                tx_q <= '0;
        else if (evt.cs_fall)   tx_q <= load_word;
        else if (evt.sclk_fall) tx_q <= {tx_q[W-2:0], chain_bit};
    end

    assign so_bit = tx_q[W-1];

endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
    import spi_chk_pkg::*;
#(
    parameter int W      = WORD_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         spi_sclk,
    input  logic         spi_cs_n,
    input  logic         spi_si,
    output logic         spi_so,
    output logic         spi_so_oe,
    input  logic [W-1:0] status_word,
    output logic [W-1:0] cmd_word,
    output logic         cmd_valid,
    output logic         parity_err,
    output logic         frame_err
);

    localparam int N_PINS = 3;

    logic [N_PINS-1:0] pins_s;
    spi_evt_t          evt;
    frame_verdict_t    verdict;
    logic [W-1:0]      rx_word;
    logic              rx_lsb;

    spi_sync #(
        .N_SIG   (N_PINS),
        .STAGES  (STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  ({spi_si, spi_cs_n, spi_sclk}),
        .q_out (pins_s)
    );

    spi_edge_det u_edge (
        .clk    (clk),
        .rst    (rst),
        .sclk_s (pins_s[0]),
        .csn_s  (pins_s[1]),
        .evt    (evt)
    );

    spi_frame_ctrl #(.W(W)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .si_s    (pins_s[2]),
        .rx_word (rx_word),
        .rx_lsb  (rx_lsb),
        .verdict (verdict)
    );

    spi_tx_shift #(.W(W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .load_word (status_word),
        .chain_bit (rx_lsb),
        .so_bit    (spi_so)
    );

    // Pad enable follows chip select directly so the line is released at once
    assign spi_so_oe = ~spi_cs_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_word   <= '0;
            cmd_valid  <= 1'b0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (verdict.done) begin
                parity_err <= verdict.par_bad;
                frame_err  <= verdict.len_bad;
                if (!verdict.par_bad && !verdict.len_bad) begin
                    cmd_word  <= rx_word;
                    cmd_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] cmd_word,
    input logic         cmd_valid,
    input logic         parity_err,
    input logic         frame_err
);

    AST_COMMIT_CLEAN: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (!parity_err && !frame_err)); // R8

    AST_COMMIT_ODD: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (^cmd_word == 1'b1)); // R7

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid); // R8

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> $stable(cmd_word)); // R8

    AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_err) |-> !cmd_valid); // R6

endmodule

bind spi_cmd_slave spi_cmd_slave_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_word   (cmd_word),
    .cmd_valid  (cmd_valid),
    .parity_err (parity_err),
    .frame_err  (frame_err)
);

// File: tb/spi_cmd_slave_tb.sv
`timescale 1ns/1ps
module spi_cmd_slave_tb;

    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_si = 1'b0;
    logic        spi_so;
    logic        spi_so_oe;
    logic [15:0] status_word = '0;
    logic [15:0] cmd_word;
    logic        cmd_valid;
    logic        parity_err;
    logic        frame_err;

    int checks = 0;
    int failures = 0;
    int strobes = 0;
    logic done = 1'b0;

    logic [15:0] exp_word = '0;

    always #2 clk = ~clk;

    spi_cmd_slave u_dut (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_si(spi_si), .spi_so(spi_so), .spi_so_oe(spi_so_oe),
        .status_word(status_word), .cmd_word(cmd_word), .cmd_valid(cmd_valid),
        .parity_err(parity_err), .frame_err(frame_err)
    );

    always @(posedge clk) if (cmd_valid) strobes <= strobes + 1;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs one frame of n serial clocks; d[n-1] is sent first
    task automatic run_frame(input int n, input logic [63:0] d, input logic [15:0] st,
                             output logic [63:0] so_cap, output logic oe_seen);
        so_cap = '0;
        oe_seen = 1'b1;
        status_word = st;
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            spi_si = d[n-1-i];
            repeat (HALF) @(negedge clk);
            so_cap[n-1-i] = spi_so;
            oe_seen = oe_seen & spi_so_oe;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    // Frame followed by full result checks against arithmetic expectations
    task automatic frame_and_check(input int n, input logic [63:0] d, input logic [15:0] st,
                                   input bit check_so);
        logic [63:0] so_cap;
        logic [63:0] so_exp;
        logic [15:0] last16;
        logic        oe_seen;
        logic        len_bad;
        logic        par_bad;
        int          s0;
        s0 = strobes;
        run_frame(n, d, st, so_cap, oe_seen);
        last16  = (n >= 16) ? d[15:0] : 16'(d & ((64'd1 << n) - 64'd1));
        len_bad = (n == 0) || (n % 16 != 0);
        par_bad = ~(^last16);
        check("R6 frame_err", 64'(frame_err), 64'(len_bad));
        check("R7 parity_err", 64'(parity_err), 64'(par_bad));
        if (!len_bad && !par_bad) exp_word = last16;
        check("R8 strobe count", 64'(strobes - s0), (!len_bad && !par_bad) ? 64'd1 : 64'd0);
        check("R3 cmd_word", 64'(cmd_word), 64'(exp_word));
        check("R2 so_oe released", 64'(spi_so_oe), 64'd0);
        if (check_so && n > 0) begin
            so_exp = '0;
            for (int i = 0; i < n; i++)
                so_exp[n-1-i] = (i < 16) ? st[15-i] : d[n-1-(i-16)];
            check((n > 16) ? "R5 chained so" : "R4 status so", so_cap, so_exp);
            check("R2 so_oe during frame", 64'(oe_seen), 64'd1);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check("R1 cmd_word reset", 64'(cmd_word), 64'd0);
        check("R1 flags reset", {61'd0, cmd_valid, parity_err, frame_err}, 64'd0);
        check("R1 so_oe reset", 64'(spi_so_oe), 64'd0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check("R1 idle after reset", {45'd0, cmd_word, cmd_valid, parity_err, frame_err}, 64'd0);

        // Sweep of frame lengths 0..40 (R6, R10, R3)
        for (int n = 0; n <= 40; n++)
            frame_and_check(n, 64'hA5C3_96F0_1E2D_3B4C ^ (64'(n) * 64'h9E37_79B9), 16'h5A00 ^ 16'(n), 1'b1);

        // Sweep of 64 single words, mixed parity (R3, R4, R7, R8, R9)
        for (int k = 0; k < 64; k++) begin
            logic [15:0] w;
            w = 16'(k * 16'h2F1B + 16'h0137);
            frame_and_check(16, {48'd0, w}, ~w, 1'b1);
        end

        // Chained two- and three-word frames (R5)
        frame_and_check(32, 64'h0000_0000_1234_8001, 16'hC3A5, 1'b1);
        frame_and_check(48, 64'h0000_7E81_0F0F_4002, 16'h0FF0, 1'b1);

        // Clean word then an empty frame: capture must be cleared (R10, R9)
        frame_and_check(16, 64'h0000_0000_0000_8000, 16'h1111, 1'b1);
        check("R9 flags cleared by clean frame", {62'd0, parity_err, frame_err}, 64'd0);
        frame_and_check(0, 64'h0, 16'h2222, 1'b0);
        check("R10 empty frame after odd word", {62'd0, parity_err, frame_err}, 64'd3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule